// File: doc/BRIEF.md
# Unlock Command Sequence Detector

This block guards a parallel-bus memory against stray programming. It watches decoded write strobes, each carrying a latched address and data byte, and looks for a fixed three-write unlock pattern. Each step of the pattern is a write to a set address with a set data value. When all three steps arrive in order, with no step further apart than the load window, the block pulses a grant. That grant lets the load controller open exactly one sector-load session. The next program operation needs the whole pattern again.

A write that breaks the pattern, or that arrives with no pattern in progress, changes no stored data. It still starts an external write-cycle timer through a start pulse, and it raises a busy flag that stays up until the timer reports done. While that flag is high, the read path treats reads as status polls and not as array reads. The detector takes no notice of writes that belong to an open load session, and none of writes made while the dummy cycle is running.

The pattern is set by parameters. By default it is 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. Protection is the state after reset.

Top module: `cmd_unlock_guard`

## Requirements
- R1: After a synchronous reset, `load_grant`, `tmr_start` and `dummy_busy` are 0, and the sequencer is idle, so no step of the pattern is counted as done.
- R2: Three accepted strobes in order, writing 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, raise `load_grant` for exactly one cycle. It rises in the cycle after the third strobe.
- R3: A grant authorises one session only. After a grant the sequencer is idle again, so a lone third-step write is rejected as unauthorised, and only a complete new pattern produces a new grant.
- R4: An accepted strobe whose address or data does not match the expected step sends the sequencer to idle. In the next cycle `tmr_start` pulses for one cycle and `dummy_busy` goes high, and no grant results. This holds even when the write matches the first step.
- R5: `dummy_busy` stays high until `tmr_done` is sampled high, and it is low in the cycle after that.
- R6: Strobes sampled while `dummy_busy` is high are ignored. They cause no `tmr_start`, no grant, and no progress through the pattern.
- R7: Strobes sampled while `load_busy` is high are ignored. They cause no `tmr_start`, no grant, and no progress through the pattern.
- R8: Once the pattern has started, if GAP_CYC cycles pass with no accepted strobe, the sequencer returns to idle with no `tmr_start`, and the next pattern step written is rejected. A gap of GAP_CYC-1 idle cycles still continues the pattern.
- R9: `load_grant` and `tmr_start` are never high in the same cycle.
- R10: A reset in the middle of the pattern returns the sequencer to idle and clears `dummy_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe for a decoded bus write |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| load_busy | input | 1 | High while the load controller owns a session; strobes then belong to it |
| tmr_done | input | 1 | The external write-cycle timer has expired |
| load_grant | output | 1 | One-cycle pulse that grants one sector-load session |
| tmr_start | output | 1 | One-cycle pulse that starts the dummy write-cycle timer |
| dummy_busy | output | 1 | Dummy write cycle in progress; reads act as status polls |

## Verification
The bench builds the block with GAP_CYC = 6 and the default 17-bit address and 8-bit data pattern. With a window that short, the abort and the last-cycle-accepted boundary both sit a few cycles from the previous step. Random idle runs in the constrained-random phase therefore cross the window often, mixed in with in-order steps, stray writes, timer-done pulses and load-session writes. The default address pattern leaves the match logic at full width, so a single flipped address or data bit is checked as a mismatch.

// File: rtl/cmd_unlock_pkg.sv
package cmd_unlock_pkg;
  localparam int NSTEPS = 3;
  typedef logic [1:0] step_t;
  localparam step_t FIRST_STEP = 2'd0;
  localparam step_t LAST_STEP  = 2'(NSTEPS - 1);
endpackage

// File: rtl/cmd_step_match.sv
module cmd_step_match #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] EXP_ADDR = '0,
  parameter logic [DATA_W-1:0] EXP_DATA = '0
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit
);
  always_comb hit = (wr_addr == EXP_ADDR) && (wr_data == EXP_DATA);
endmodule

// File: rtl/gap_window_timer.sv
module gap_window_timer #(
  parameter int GAP_CYC = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic accept,
  output logic expire
);
  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] idle_cnt;

  always_comb expire = armed && !accept && (idle_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (accept || !armed || expire) begin
      idle_cnt <= '0;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R8: the idle count never passes the window limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= CNT_LAST);
  // R8: an expiry leaves the count cleared for the next cycle
  p_expire_clears_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> idle_cnt == '0);
endmodule

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
  import cmd_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [NSTEPS-1:0] hit,
  input  logic              expire,
  output step_t             step_idx,
  output logic              armed,
  output logic              reject,
  output logic              grant
);
  logic step_ok;

  always_comb begin
    step_ok = hit[step_idx];
    reject  = accept && !step_ok;
    armed   = (step_idx != FIRST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_idx <= FIRST_STEP;
      grant    <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (accept) begin
        if (step_ok && step_idx == LAST_STEP) begin
          step_idx <= FIRST_STEP;
          grant    <= 1'b1;
        end else if (step_ok) begin
          step_idx <= step_idx + 1'b1;
        end else begin
          step_idx <= FIRST_STEP;
        end
      end else if (expire) begin
        step_idx <= FIRST_STEP;
      end
    end
  end

  // R2: the grant is a single-cycle pulse
  p_grant_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);
  // R2: a grant only follows the final step
  p_grant_from_last_r2: assert property (@(posedge clk) disable iff (rst)
    grant |-> $past(step_idx) == LAST_STEP);
  // R3: after a grant the sequencer is back at idle
  p_idle_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
    grant |-> step_idx == FIRST_STEP);
  // R4: a rejected write returns the sequencer to idle
  p_reject_idle_r4: assert property (@(posedge clk) disable iff (rst)
    reject |=> step_idx == FIRST_STEP && !grant);
  // R4: the step index never leaves its legal range
  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    step_idx <= LAST_STEP);
endmodule

// File: rtl/dummy_cycle_ctrl.sv
module dummy_cycle_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic reject,
  input  logic tmr_done,
  output logic tmr_start,
  output logic dummy_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_start  <= 1'b0;
      dummy_busy <= 1'b0;
    end else begin
      tmr_start <= reject && !dummy_busy;
      if (dummy_busy) begin
        if (tmr_done) dummy_busy <= 1'b0;
      end else if (reject) begin
        dummy_busy <= 1'b1;
      end
    end
  end

  // R4: a timer start always comes with the busy flag
  p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
    tmr_start |-> dummy_busy);
  // R5: busy holds until the timer reports done
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dummy_busy && !tmr_done) |=> dummy_busy);
  // R5: busy drops one cycle after timer done
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (dummy_busy && tmr_done) |=> !dummy_busy);
endmodule

// File: rtl/cmd_unlock_guard.sv
module cmd_unlock_guard
  import cmd_unlock_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int GAP_CYC = 7500,
  parameter logic [NSTEPS*ADDR_W-1:0] CMD_ADDRS = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [NSTEPS*DATA_W-1:0] CMD_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_busy,
  input  logic              tmr_done,
  output logic              load_grant,
  output logic              tmr_start,
  output logic              dummy_busy
);
  logic [NSTEPS-1:0] step_hit;
  logic              accept;
  logic              armed;
  logic              reject;
  logic              expire;
  step_t             step_idx;

  always_comb accept = wr_stb && !load_busy && !dummy_busy;

  for (genvar i = 0; i < NSTEPS; i++) begin : g_step
    cmd_step_match #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .EXP_ADDR(CMD_ADDRS[i*ADDR_W +: ADDR_W]),
      .EXP_DATA(CMD_DATAS[i*DATA_W +: DATA_W])
    ) u_match (
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .hit    (step_hit[i])
    );
  end

  unlock_seq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .hit     (step_hit),
    .expire  (expire),
    .step_idx(step_idx),
    .armed   (armed),
    .reject  (reject),
    .grant   (load_grant)
  );

  gap_window_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .armed (armed),
    .accept(accept),
    .expire(expire)
  );

  dummy_cycle_ctrl u_dummy (
    .clk       (clk),
    .rst       (rst),
    .reject    (reject),
    .tmr_done  (tmr_done),
    .tmr_start (tmr_start),
    .dummy_busy(dummy_busy)
  );

  // R9: grant and timer start are mutually exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(load_grant && tmr_start));
  // R6: writes during a dummy cycle have no effect
  p_ignore_dummy_r6: assert property (@(posedge clk) disable iff (rst)
    (dummy_busy && wr_stb) |=> !tmr_start && !load_grant);
  // R7: writes during a load session have no effect
  p_ignore_load_r7: assert property (@(posedge clk) disable iff (rst)
    load_busy |=> !tmr_start && !load_grant);
  // R8: a silent abort never starts the timer
  p_abort_silent_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !tmr_start && !load_grant);
endmodule

// File: tb/cmd_unlock_guard_test.sv
module cmd_unlock_guard_test;
  localparam int CLK_PER = 10;
  localparam int GAP = 6;
  localparam int AW = 17;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic load_busy = 1'b0;
  logic tmr_done = 1'b0;
  logic load_grant, tmr_start, dummy_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model state
  int m_idx = 0;
  int m_cnt = 0;
  bit m_busy = 1'b0;
  bit e_grant = 1'b0;
  bit e_start = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  cmd_unlock_guard #(.GAP_CYC(GAP)) uut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_busy(load_busy), .tmr_done(tmr_done),
    .load_grant(load_grant), .tmr_start(tmr_start), .dummy_busy(dummy_busy)
  );

  function automatic logic [AW-1:0] step_addr(input int i);
    return (i == 1) ? 17'h02AAA : 17'h05555;
  endfunction
  function automatic logic [DW-1:0] step_data(input int i);
    return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : 8'hA0;
  endfunction

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input bit stb, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit td, input bit lb);
    e_grant = 1'b0;
    e_start = 1'b0;
    if (m_busy) begin
      if (td) m_busy = 1'b0;
    end else if (stb && !lb) begin
      m_cnt = 0;
      if (a == step_addr(m_idx) && d == step_data(m_idx)) begin
        if (m_idx == 2) begin m_idx = 0; e_grant = 1'b1; end
        else m_idx++;
      end else begin
        m_idx = 0; m_busy = 1'b1; e_start = 1'b1;
      end
    end else if (m_idx != 0) begin
      if (m_cnt == GAP - 1) begin m_idx = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic tick(input bit stb, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit td, input bit lb, input string req);
    @(negedge clk);
    wr_stb = stb; wr_addr = a; wr_data = d; tmr_done = td; load_busy = lb;
    @(posedge clk);
    model(stb, a, d, td, lb);
    #(CLK_PER/4);
    chk(load_grant == e_grant, req, "load_grant", load_grant, e_grant);
    chk(tmr_start == e_start, req, "tmr_start", tmr_start, e_start);
    chk(dummy_busy == m_busy, req, "dummy_busy", dummy_busy, m_busy);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(1'b0, '0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic wr(input int step, input string req);
    tick(1'b1, step_addr(step), step_data(step), 1'b0, 1'b0, req);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; wr_stb = 1'b0; tmr_done = 1'b0; load_busy = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_idx = 0; m_cnt = 0; m_busy = 1'b0;
    chk(load_grant == 1'b0, req, "grant after reset", load_grant, 0);
    chk(tmr_start == 1'b0, req, "start after reset", tmr_start, 0);
    chk(dummy_busy == 1'b0, req, "busy after reset", dummy_busy, 0);
  endtask

  task automatic clear_busy(input string req);
    tick(1'b0, '0, '0, 1'b1, 1'b0, req);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, then step 2 write alone is rejected
    do_reset("R1");
    wr(2, "R1");
    chk(tmr_start == 1'b1, "R1", "lone last step rejected", tmr_start, 1);
    clear_busy("R1");

    // R2: the full pattern back to back
    wr(0, "R2"); wr(1, "R2"); wr(2, "R2");
    chk(load_grant == 1'b1, "R2", "grant on third step", load_grant, 1);
    idle(1, "R2");
    chk(load_grant == 1'b0, "R2", "grant one cycle", load_grant, 0);

    // R3: one grant per pattern
    wr(2, "R3");
    chk(dummy_busy == 1'b1 && load_grant == 1'b0, "R3", "no second grant", load_grant, 0);
    clear_busy("R3");
    wr(0, "R3"); wr(1, "R3"); wr(2, "R3");
    chk(load_grant == 1'b1, "R3", "new pattern grants", load_grant, 1);

    // R4: wrong data at step 1, and first-step repeat at step 1
    wr(0, "R4");
    tick(1'b1, 17'h02AAA, 8'h54, 1'b0, 1'b0, "R4");
    chk(tmr_start == 1'b1, "R4", "mismatch starts timer", tmr_start, 1);
    clear_busy("R4");
    wr(0, "R4"); wr(0, "R4");
    chk(tmr_start == 1'b1, "R4", "repeat first step rejected", tmr_start, 1);

    // R5: busy holds without done, then clears
    idle(5, "R5");
    chk(dummy_busy == 1'b1, "R5", "busy held", dummy_busy, 1);
    clear_busy("R5");
    chk(dummy_busy == 1'b0, "R5", "busy cleared", dummy_busy, 0);

    // R6: pattern during busy is ignored
    tick(1'b1, 17'h00001, 8'h00, 1'b0, 1'b0, "R6");
    wr(0, "R6"); wr(1, "R6"); wr(2, "R6");
    chk(load_grant == 1'b0 && tmr_start == 1'b0, "R6", "ignored while busy", load_grant, 0);
    clear_busy("R6");

    // R7: pattern during load session is ignored
    tick(1'b1, step_addr(0), step_data(0), 1'b0, 1'b1, "R7");
    tick(1'b1, step_addr(1), step_data(1), 1'b0, 1'b1, "R7");
    tick(1'b1, step_addr(2), step_data(2), 1'b0, 1'b1, "R7");
    chk(load_grant == 1'b0 && dummy_busy == 1'b0, "R7", "ignored in session", load_grant, 0);
    tick(1'b1, 17'h01234, 8'h77, 1'b0, 1'b1, "R7");
    chk(tmr_start == 1'b0, "R7", "no timer in session", tmr_start, 0);

    // R8: window boundary
    wr(0, "R8"); idle(GAP - 1, "R8"); wr(1, "R8"); idle(GAP - 1, "R8"); wr(2, "R8");
    chk(load_grant == 1'b1, "R8", "last-cycle step accepted", load_grant, 1);
    wr(0, "R8"); idle(GAP, "R8");
    chk(tmr_start == 1'b0, "R8", "silent abort", tmr_start, 0);
    wr(1, "R8");
    chk(tmr_start == 1'b1, "R8", "step after abort rejected", tmr_start, 1);
    clear_busy("R8");

    // R10: reset mid-pattern
    wr(0, "R10"); wr(1, "R10");
    do_reset("R10");
    wr(2, "R10");
    chk(tmr_start == 1'b1 && load_grant == 1'b0, "R10", "idle after reset", tmr_start, 1);
    tick(1'b1, 17'h0, 8'h0, 1'b0, 1'b0, "R10");
    do_reset("R10");

    // R9 and mixed: constrained random against the model
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = $urandom % 12;
      if (r < 5)       tick(1'b1, step_addr(m_idx), step_data(m_idx), 1'b0, 1'b0, "R9");
      else if (r == 5) tick(1'b1, AW'($urandom), DW'($urandom), 1'b0, 1'b0, "R9");
      else if (r == 6) tick(1'b1, step_addr($urandom % 3), step_data($urandom % 3), 1'b0, 1'b0, "R9");
      else if (r == 7) tick(1'b0, '0, '0, 1'b1, 1'b0, "R9");
      else if (r == 8) tick(1'b1, AW'($urandom), DW'($urandom), 1'b0, 1'b1, "R9");
      else             idle(int'($urandom % (GAP + 2)), "R9");
      checks++;
      if (load_grant && tmr_start) begin
        errors++;
        $display("FAIL R9: actual grant and start together expected exclusive");
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule